// File: doc/BRIEF.md
# Streaming DMA Descriptor Validator

This block inspects a DMA descriptor of sixteen 32-bit words while the words stream past it, one word for each cycle in which the valid input is high. Idle cycles may fall between words. The block keeps no copy of the descriptor. As the words go by it captures only the fields it needs and keeps a running 32-bit sum. When the sixteenth word has been accepted, it issues a one-cycle verdict. The verdict says whether the descriptor can be used or names the first rule it breaks.

The verdict comes with the decoded control flags and a 48-bit address for the next descriptor. A fetch engine can therefore decide, from one strobe, whether to process the descriptor, where the chain continues and whether the chain ends here. Word positions within the descriptor: word 0 is control, word 5 is the high timestamp, word 6 carries the address extension, word 7 is the next-descriptor address and word 15 is the checksum. The other words take part only in the sum.

Top module: `dma_desc_validator`

## Requirements
- R1: Words are numbered 0 to 15 in order of acceptance (cycles with `beat_valid` high), whatever idle gaps lie between them. `res_valid` is high exactly in the cycle that follows the clock edge at which word 15 is accepted.
- R2: When control bits [7:0] differ from 0xA5, `res_code` is 1 (bad preamble).
- R3: When control bit 20 is set, word 15 must equal the 32-bit wrapping sum of words 0 to 14, and otherwise `res_code` is 2 (bad checksum). When bit 20 is clear, word 15 has no effect on the verdict.
- R4: When bit 31 of word 5 is set and control bit 10 is clear, `res_code` is 3 (already done). With control bit 10 set, the done flag has no effect.
- R5: Checks run in priority order: preamble first, then checksum, then done flag. The first one that fails is reported. `res_code` is 0 when all pass.
- R6: The flag outputs are taken from control bits with the verdict: `irq_en` = bit 8, `wb_en` = bit 9, `ign_done` = bit 10, `frag_mode` = bit 18 (0 means contiguous), `last_desc` = bit 19, `last_frame` = bit 21. `chain_end` is high when bit 19 or bit 21 is set.
- R7: `next_addr` equals word 7 in bits [47:16] and word 6 bits [15:0] in bits [15:0]. The upper half of word 6 is ignored.
- R8: `res_valid` lasts one cycle. `res_code` is 0 whenever `res_valid` is low. The flag outputs and `next_addr` hold their last verdict values until the next verdict.
- R9: After reset, `res_valid`, `res_code`, all flags and `next_addr` are 0.
- R10: The running sum and the word count start afresh with each descriptor, including descriptors sent back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A descriptor word is present on `beat_data` |
| beat_data | input | 32 | Descriptor word |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_code | output | 2 | 0 valid, 1 bad preamble, 2 bad checksum, 3 already done |
| irq_en | output | 1 | Completion interrupt enable flag |
| wb_en | output | 1 | Done write-back enable flag |
| ign_done | output | 1 | Ignore-done flag |
| frag_mode | output | 1 | Fragmented mode (0 contiguous) |
| last_desc | output | 1 | Last descriptor flag |
| last_frame | output | 1 | Last descriptor of a frame |
| chain_end | output | 1 | Either of the two last flags |
| next_addr | output | 48 | Next-descriptor address |

## Verification
The hardest cases are descriptors that break two or three rules at once. In those cases the priority order alone decides the reported code. They arise only from crafted word sets. The bench builds them by setting the preamble, the checksum-enable bit, a deliberately wrong word 15 and the done flag together. It also uses large word values so that the sum wraps past 32 bits. A second hard case is a descriptor that starts in the same cycle as the previous verdict. The bench sends descriptors back to back and also with idle gaps. During the gaps it drives junk data, which must not be counted.

// File: rtl/ddv_pkg.sv
package ddv_pkg;

    typedef enum logic [1:0] {
        VERD_OK       = 2'd0,
        VERD_PREAMBLE = 2'd1,
        VERD_SUM      = 2'd2,
        VERD_DONE     = 2'd3
    } verdict_e;

    typedef struct packed {
        logic irq_en;
        logic wb_en;
        logic ign_done;
        logic frag_mode;
        logic last_desc;
        logic last_frame;
    } ctl_flags_t;

    // control-word bit positions decoded by the neighbouring fetch engine
    localparam int unsigned PRE_LSB      = 0;
    localparam int unsigned PRE_W        = 8;
    localparam int unsigned BIT_IRQ      = 8;
    localparam int unsigned BIT_WB       = 9;
    localparam int unsigned BIT_IGN      = 10;
    localparam int unsigned BIT_FRAG     = 18;
    localparam int unsigned BIT_LAST     = 19;
    localparam int unsigned BIT_SUM_EN   = 20;
    localparam int unsigned BIT_LASTFRM  = 21;
    localparam int unsigned BIT_DONE     = 31;

endpackage

// File: rtl/ddv_beat_counter.sv
module ddv_beat_counter #(
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (beat_valid) begin
            if (cnt_q.idx == LAST_IDX) begin
                cnt_d.idx = '0;
            end else begin
                cnt_d.idx = cnt_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idx     = cnt_q.idx;
    assign at_last = (cnt_q.idx == LAST_IDX);

endmodule

// File: rtl/ddv_field_capture.sv
module ddv_field_capture
    import ddv_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 16,
    parameter int unsigned EXT_W     = 16,
    parameter int unsigned CTRL_IDX  = 0,
    parameter int unsigned TSHI_IDX  = 5,
    parameter int unsigned EXT_IDX   = 6,
    parameter int unsigned NEXT_IDX  = 7,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    input  logic [IDX_W-1:0]  idx,
    output logic [PRE_W-1:0]  pre,
    output logic              sum_en,
    output logic              done_flag,
    output ctl_flags_t        flags,
    output logic [EXT_W-1:0]  ext,
    output logic [WORD_W-1:0] nxt,
    output logic [WORD_W-1:0] sum
);
    localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);
    localparam logic [IDX_W-1:0] I_TSHI = IDX_W'(TSHI_IDX);
    localparam logic [IDX_W-1:0] I_EXT  = IDX_W'(EXT_IDX);
    localparam logic [IDX_W-1:0] I_NEXT = IDX_W'(NEXT_IDX);
    localparam logic [IDX_W-1:0] I_SUM  = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic              sum_en;
        logic              done;
        ctl_flags_t        fl;
        logic [EXT_W-1:0]  ext;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] sum;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (beat_valid) begin
            // running sum covers every word ahead of the checksum word
            if (idx == I_CTRL) begin
                cap_d.sum = beat_data;
            end else if (idx != I_SUM) begin
                cap_d.sum = cap_q.sum + beat_data;
            end
            if (idx == I_CTRL) begin
                cap_d.pre           = beat_data[PRE_LSB +: PRE_W];
                cap_d.sum_en        = beat_data[BIT_SUM_EN];
                cap_d.fl.irq_en     = beat_data[BIT_IRQ];
                cap_d.fl.wb_en      = beat_data[BIT_WB];
                cap_d.fl.ign_done   = beat_data[BIT_IGN];
                cap_d.fl.frag_mode  = beat_data[BIT_FRAG];
                cap_d.fl.last_desc  = beat_data[BIT_LAST];
                cap_d.fl.last_frame = beat_data[BIT_LASTFRM];
            end
            if (idx == I_TSHI) begin
                cap_d.done = beat_data[BIT_DONE];
            end
            if (idx == I_EXT) begin
                cap_d.ext = beat_data[EXT_W-1:0];
            end
            if (idx == I_NEXT) begin
                cap_d.nxt = beat_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pre       = cap_q.pre;
    assign sum_en    = cap_q.sum_en;
    assign done_flag = cap_q.done;
    assign flags     = cap_q.fl;
    assign ext       = cap_q.ext;
    assign nxt       = cap_q.nxt;
    assign sum       = cap_q.sum;

endmodule

// File: rtl/ddv_verdict.sv
module ddv_verdict
    import ddv_pkg::*;
#(
    parameter int unsigned WORD_W       = 32,
    parameter int unsigned EXT_W        = 16,
    parameter logic [7:0]  PREAMBLE_VAL = 8'hA5,
    localparam int unsigned ADDR_W      = WORD_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] chk_word,
    input  logic [PRE_W-1:0]  pre,
    input  logic              sum_en,
    input  logic              done_flag,
    input  ctl_flags_t        flags_in,
    input  logic [EXT_W-1:0]  ext,
    input  logic [WORD_W-1:0] nxt,
    input  logic [WORD_W-1:0] sum,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output ctl_flags_t        flags_out,
    output logic              chain_end,
    output logic [ADDR_W-1:0] next_addr
);
    typedef struct packed {
        logic              vld;
        verdict_e          code;
        ctl_flags_t        fl;
        logic              chain;
        logic [ADDR_W-1:0] addr;
    } res_t;

    res_t res_d, res_q;
    logic pre_bad, sum_bad, done_bad;

    always_comb begin
        pre_bad  = (pre != PREAMBLE_VAL);
        sum_bad  = sum_en && (sum != chk_word);
        done_bad = done_flag && !flags_in.ign_done;

        res_d      = res_q;
        res_d.vld  = 1'b0;
        res_d.code = VERD_OK;
        if (fire) begin
            res_d.vld = 1'b1;
            if (pre_bad) begin
                res_d.code = VERD_PREAMBLE;
            end else if (sum_bad) begin
                res_d.code = VERD_SUM;
            end else if (done_bad) begin
                res_d.code = VERD_DONE;
            end else begin
                res_d.code = VERD_OK;
            end
            res_d.fl    = flags_in;
            res_d.chain = flags_in.last_desc | flags_in.last_frame;
            res_d.addr  = {nxt, ext};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign res_code  = res_q.code;
    assign flags_out = res_q.fl;
    assign chain_end = res_q.chain;
    assign next_addr = res_q.addr;

endmodule

// File: rtl/dma_desc_validator.sv
module dma_desc_validator
    import ddv_pkg::*;
#(
    parameter int unsigned WORD_W       = 32,
    parameter int unsigned NUM_WORDS    = 16,
    parameter int unsigned EXT_W        = 16,
    parameter logic [7:0]  PREAMBLE_VAL = 8'hA5,
    localparam int unsigned ADDR_W      = WORD_W + EXT_W,
    localparam int unsigned IDX_W       = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic              irq_en,
    output logic              wb_en,
    output logic              ign_done,
    output logic              frag_mode,
    output logic              last_desc,
    output logic              last_frame,
    output logic              chain_end,
    output logic [ADDR_W-1:0] next_addr
);
    logic [IDX_W-1:0]  beat_idx;
    logic              beat_last;
    logic [PRE_W-1:0]  c_pre;
    logic              c_sum_en;
    logic              c_done;
    ctl_flags_t        c_flags;
    ctl_flags_t        o_flags;
    logic [EXT_W-1:0]  c_ext;
    logic [WORD_W-1:0] c_nxt;
    logic [WORD_W-1:0] c_sum;

    ddv_beat_counter #(.NUM_WORDS(NUM_WORDS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .idx        (beat_idx),
        .at_last    (beat_last)
    );

    ddv_field_capture #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .EXT_W     (EXT_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .idx        (beat_idx),
        .pre        (c_pre),
        .sum_en     (c_sum_en),
        .done_flag  (c_done),
        .flags      (c_flags),
        .ext        (c_ext),
        .nxt        (c_nxt),
        .sum        (c_sum)
    );

    ddv_verdict #(
        .WORD_W       (WORD_W),
        .EXT_W        (EXT_W),
        .PREAMBLE_VAL (PREAMBLE_VAL)
    ) u_ver (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (beat_valid && beat_last),
        .chk_word  (beat_data),
        .pre       (c_pre),
        .sum_en    (c_sum_en),
        .done_flag (c_done),
        .flags_in  (c_flags),
        .ext       (c_ext),
        .nxt       (c_nxt),
        .sum       (c_sum),
        .res_valid (res_valid),
        .res_code  (res_code),
        .flags_out (o_flags),
        .chain_end (chain_end),
        .next_addr (next_addr)
    );

    assign irq_en     = o_flags.irq_en;
    assign wb_en      = o_flags.wb_en;
    assign ign_done   = o_flags.ign_done;
    assign frag_mode  = o_flags.frag_mode;
    assign last_desc  = o_flags.last_desc;
    assign last_frame = o_flags.last_frame;

endmodule

// File: rtl/ddv_checker.sv
module ddv_checker #(
    parameter int unsigned NUM_WORDS = 16,
    parameter int unsigned ADDR_W    = 48,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              beat_valid,
    input logic [IDX_W-1:0]  idx,
    input logic              res_valid,
    input logic [1:0]        res_code,
    input logic              chain_end,
    input logic              last_desc,
    input logic              last_frame,
    input logic [ADDR_W-1:0] next_addr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    // R8
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R1
    res_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(beat_valid && idx == LAST_IDX));

    // R1
    last_gives_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && idx == LAST_IDX) |=> res_valid);

    // R8
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> res_code == 2'd0);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(next_addr) && $stable(chain_end)
                        && $stable(last_desc) && $stable(last_frame)));

endmodule

bind dma_desc_validator ddv_checker #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .idx        (beat_idx),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .chain_end  (chain_end),
    .last_desc  (last_desc),
    .last_frame (last_frame),
    .next_addr  (next_addr)
);

// File: tb/sim_dma_desc_validator.sv
module sim_dma_desc_validator;

    typedef logic [31:0] desc_t [16];

    typedef struct {
        logic [1:0]  code;
        logic [6:0]  fl;
        logic [47:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic        res_valid;
    logic [1:0]  res_code;
    logic        irq_en, wb_en, ign_done, frag_mode, last_desc, last_frame, chain_end;
    logic [47:0] next_addr;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    dma_desc_validator u0 (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_data(beat_data),
        .res_valid(res_valid), .res_code(res_code), .irq_en(irq_en), .wb_en(wb_en),
        .ign_done(ign_done), .frag_mode(frag_mode), .last_desc(last_desc),
        .last_frame(last_frame), .chain_end(chain_end), .next_addr(next_addr)
    );

    function automatic logic [6:0] out_flags();
        return {chain_end, last_frame, last_desc, frag_mode, ign_done, wb_en, irq_en};
    endfunction

    function automatic desc_t mk(logic [31:0] ctrl, logic done, logic [15:0] ext16,
                                 logic [31:0] nxt, logic [31:0] seed, logic bad_sum);
        desc_t w;
        logic [31:0] s;
        w[0] = ctrl;
        w[1] = seed;
        w[2] = seed * 3;
        w[3] = seed ^ 32'h0F0F_0F0F;
        w[4] = seed ^ 32'hDEAD_BEEF;
        w[5] = {done, seed[30:0]};
        w[6] = {16'hABCD, ext16};
        w[7] = nxt;
        for (int i = 8; i < 15; i++) w[i] = seed + 32'(i) * 32'h9357_9BDF;
        s = '0;
        for (int i = 0; i < 15; i++) s = s + w[i];
        w[15] = bad_sum ? s + 32'd1 : s;
        return w;
    endfunction

    function automatic exp_t predict(desc_t w, string tag);
        exp_t e;
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 15; i++) s = s + w[i];
        if (w[0][7:0] != 8'hA5)                e.code = 2'd1;
        else if (w[0][20] && s != w[15])       e.code = 2'd2;
        else if (w[5][31] && !w[0][10])        e.code = 2'd3;
        else                                   e.code = 2'd0;
        e.fl   = {w[0][19] | w[0][21], w[0][21], w[0][19], w[0][18], w[0][10], w[0][9], w[0][8]};
        e.addr = {w[7], w[6][15:0]};
        e.tag  = tag;
        return e;
    endfunction

    task automatic send(desc_t w, int gap, string tag);
        sb.push_back(predict(w, tag));
        for (int i = 0; i < 16; i++) begin
            beat_valid = 1'b1;
            beat_data  = w[i];
            @(posedge clk); #2;
            if (gap > 0 && i < 15) begin
                beat_valid = 1'b0;
                beat_data  = 32'hFFFF_FFFF - 32'(i);
                repeat (gap) @(posedge clk);
                #2;
            end
        end
        beat_valid = 1'b0;
        beat_data  = 32'h5555_5555;
    endtask

    // scoreboard monitor
    logic        armed = 1'b0;
    logic [47:0] held_addr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (sb.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R1 unexpected verdict: actual code=%0d expected none", res_code);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    n_chk++;
                    if (res_code !== e.code) begin
                        n_bad++;
                        $display("FAIL %s code: actual %0d expected %0d", e.tag, res_code, e.code);
                    end
                    n_chk++;
                    if (out_flags() !== e.fl) begin
                        n_bad++;
                        $display("FAIL R6 %s flags: actual %b expected %b", e.tag, out_flags(), e.fl);
                    end
                    n_chk++;
                    if (next_addr !== e.addr) begin
                        n_bad++;
                        $display("FAIL R7 %s addr: actual %h expected %h", e.tag, next_addr, e.addr);
                    end
                end
                armed     <= 1'b1;
                held_addr <= next_addr;
            end else if (armed) begin
                armed <= 1'b0;
                n_chk++;
                if (res_code !== 2'd0 || next_addr !== held_addr) begin
                    n_bad++;
                    $display("FAIL R8 hold: actual code=%0d addr=%h expected code=0 addr=%h",
                             res_code, next_addr, held_addr);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        n_chk++;
        if (res_valid !== 1'b0 || res_code !== 2'd0 || next_addr !== 48'd0 || out_flags() !== 7'd0) begin
            n_bad++;
            $display("FAIL R9 reset: actual v=%b code=%0d addr=%h fl=%b expected all zero",
                     res_valid, res_code, next_addr, out_flags());
        end
        @(posedge clk); #2;

        // R1 R6 R7 plain valid descriptor, no checksum
        send(mk(32'h0000_03A5, 1'b0, 16'h1234, 32'h8000_0040, 32'h1111_0000, 1'b0), 0, "R1");
        repeat (2) @(posedge clk); #2;
        // R2 bad preamble
        send(mk(32'h0008_015A, 1'b0, 16'h0001, 32'h0000_1000, 32'h2222_0000, 1'b0), 0, "R2");
        repeat (2) @(posedge clk); #2;
        // R3 checksum enabled and correct, large words so the sum wraps
        send(mk(32'h0014_00A5, 1'b0, 16'hFFFF, 32'hFFFF_FFF0, 32'hF000_0001, 1'b0), 0, "R3");
        // R3 checksum enabled and wrong
        send(mk(32'h0010_00A5, 1'b0, 16'h0002, 32'h0000_2000, 32'hE000_0003, 1'b1), 0, "R3");
        // R3 checksum disabled, word 15 wrong has no effect
        send(mk(32'h0000_00A5, 1'b0, 16'h0003, 32'h0000_3000, 32'h3333_0000, 1'b1), 0, "R3");
        // R4 done flag without ignore
        send(mk(32'h0020_02A5, 1'b1, 16'h0004, 32'h0000_4000, 32'h4444_0000, 1'b0), 1, "R4");
        // R4 done flag with ignore
        send(mk(32'h0020_04A5, 1'b1, 16'h0005, 32'h0000_5000, 32'h5555_0000, 1'b0), 0, "R4");
        // R5 all three faults, preamble wins
        send(mk(32'h0010_0000, 1'b1, 16'h0006, 32'h0000_6000, 32'h6666_0000, 1'b1), 0, "R5");
        // R5 checksum and done, checksum wins
        send(mk(32'h0010_00A5, 1'b1, 16'h0007, 32'h0000_7000, 32'h7777_0000, 1'b1), 0, "R5");
        // R5 done only after passing checksum
        send(mk(32'h0010_00A5, 1'b1, 16'h0008, 32'h0000_8000, 32'h8888_0000, 1'b0), 2, "R5");
        // R1 idle gaps of three cycles with junk data
        send(mk(32'h0028_01A5, 1'b0, 16'h0009, 32'h0000_9000, 32'h9999_0000, 1'b0), 3, "R1");
        // R10 back to back, each with checksum enabled
        send(mk(32'h0018_00A5, 1'b0, 16'h000A, 32'h0000_A000, 32'hFFFF_FFFF, 1'b0), 0, "R10");
        send(mk(32'h0012_00A5, 1'b0, 16'h000B, 32'h0000_B000, 32'h8000_0000, 1'b0), 0, "R10");
        send(mk(32'h0010_00A5, 1'b0, 16'h000C, 32'h0000_C000, 32'h0000_0001, 1'b1), 0, "R10");
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing verdicts: actual %0d pending expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule